// File: doc/BRIEF.md
# Thresholded Per-Cycle Event Counter

This block is one performance-monitor counter. Every clock cycle it receives a multi-bit number that says how many times a monitored event occurred in that cycle. A programmable qualifier compares that number against a threshold. The counter adds to a wide accumulator only in cycles where the comparison holds.

When the comparison holds, the counter adds one of two amounts. In event mode it adds the raw per-cycle count. In cycle mode it adds one, so it counts qualifying cycles rather than events.

The counter has a fixed threshold capability, which it reports on an output. It refuses any configuration whose threshold goes beyond that capability and keeps the configuration it already had. Software-side plumbing sits outside the block. The counter is driven by plain strobes for configuration, preload and overflow clear.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the accumulator, the overflow flag and the config-error flag are 0, and the stored configuration is all zero, so the counter adds the raw per-cycle count.
- R2: While the stored threshold is 0, every enabled cycle adds the raw event count, whatever the comparison selector and the count-mode bit hold.
- R3: The comparison selector codes are 0 for not-equal, 1 for equal, 2 for greater-or-equal and 3 for less-than. Each is evaluated as (event count, zero-extended to 12 bits) against (threshold).
- R4: With a nonzero threshold and count-mode at 0, a cycle whose comparison holds adds the full event count, and a cycle whose comparison fails adds nothing.
- R5: With a nonzero threshold and count-mode at 1, a cycle whose comparison holds adds exactly 1, whatever the event count is. This includes an event count of 0.
- R6: The 12-bit capability output `thresh_cap` reports the largest accepted threshold, set by parameter `THR_MAX`. Values above 4095 are clamped to 4095.
- R7: A configuration write with a threshold at or below the capability is stored at the write edge and governs counting from the next cycle. It also clears the config-error flag.
- R8: A configuration write with a threshold above the capability sets the config-error flag and leaves the stored configuration unchanged.
- R9: When the capability is 0, any write with a nonzero threshold is rejected as in R8.
- R10: While `cnt_en` is 0 and no load is requested, the accumulator holds its value.
- R11: A load strobe sets the accumulator to `load_val` at the next edge. A load takes priority over counting in the same cycle.
- R12: An add that carries out of the accumulator wraps it and sets a sticky overflow flag. `ovf_clr` clears the flag, and a wrap in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting enable |
| evt_count | input | EVT_W | Event occurrences in this cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_thresh | input | 12 | Threshold to write |
| cfg_cmp | input | 2 | Comparison selector to write |
| cfg_unit | input | 1 | Count-mode to write (1 = add one per qualifying cycle) |
| load_en | input | 1 | Accumulator preload strobe |
| load_val | input | ACC_W | Preload value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| acc_out | output | ACC_W | Accumulated count |
| ovf_flag | output | 1 | Sticky wrap indicator |
| cfg_err | output | 1 | Last configuration write was rejected |
| thresh_cap | output | 12 | Largest accepted threshold |

## Verification
The main instance is built with `ACC_W` = 16 and `THR_MAX` = 255. The 16-bit accumulator lets a preload just below full scale, followed by a few adds, reach the wrap and the overflow flag. The 255 capability lets writes of 256 and 4095 exercise rejection, while thresholds 4 and 255 exercise every relation. A second instance with `THR_MAX` = 0 shares the stimulus, so the first nonzero threshold write shows the no-capability rejection.

// File: rtl/evt_thr_pkg.sv
package evt_thr_pkg;

    // Width of the threshold configuration field
    localparam int THR_FIELD_W = 12;
    localparam int THR_FIELD_MAX = (1 << THR_FIELD_W) - 1;

    typedef enum logic [1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_sel_e;

    typedef struct packed {
        logic [THR_FIELD_W-1:0] thresh;
        cmp_sel_e               cmp;
        logic                   unit;
    } thr_cfg_t;

endpackage

// File: rtl/evt_thr_cfg.sv
module evt_thr_cfg
    import evt_thr_pkg::*;
#(
    parameter int THR_MAX = 255
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  thr_cfg_t wr_cfg,
    output thr_cfg_t cfg_q,
    output logic     err_q,
    output logic [THR_FIELD_W-1:0] cap
);

    localparam int CAP_INT = (THR_MAX > THR_FIELD_MAX) ? THR_FIELD_MAX :
                             ((THR_MAX < 0) ? 0 : THR_MAX);
    localparam logic [THR_FIELD_W-1:0] CAP = CAP_INT[THR_FIELD_W-1:0];

    typedef struct packed {
        thr_cfg_t cfg;
        logic     err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    reject;

    always_comb begin
        st_d   = st_q;
        reject = (wr_cfg.thresh > CAP);
        if (wr) begin
            st_d.err = reject;
            if (!reject) begin
                st_d.cfg = wr_cfg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;
    assign err_q = st_q.err;
    assign cap   = CAP;

    // R8
    rejected_cfg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wr_cfg.thresh > CAP)) |=> ($stable(cfg_q) && err_q));

    // R7
    accepted_cfg_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wr_cfg.thresh <= CAP)) |=> ((cfg_q == $past(wr_cfg)) && !err_q));

endmodule

// File: rtl/evt_thr_qual.sv
module evt_thr_qual
    import evt_thr_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic [EVT_W-1:0] evt,
    input  thr_cfg_t         cfg,
    output logic [EVT_W-1:0] inc
);

    localparam int CMP_W = (EVT_W > THR_FIELD_W) ? EVT_W : THR_FIELD_W;

    logic [CMP_W-1:0] evt_x;
    logic [CMP_W-1:0] thr_x;
    logic             hit;

    always_comb begin
        evt_x = CMP_W'(evt);
        thr_x = CMP_W'(cfg.thresh);
        unique case (cfg.cmp)
            CMP_NE:  hit = (evt_x != thr_x);
            CMP_EQ:  hit = (evt_x == thr_x);
            CMP_GE:  hit = (evt_x >= thr_x);
            default: hit = (evt_x <  thr_x);
        endcase

        if (cfg.thresh == '0) begin
            inc = evt;
        end else if (!hit) begin
            inc = '0;
        end else if (cfg.unit) begin
            inc = EVT_W'(1);
        end else begin
            inc = evt;
        end
    end

endmodule

// File: rtl/evt_thr_accum.sv
module evt_thr_accum #(
    parameter int ACC_W = 64,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [EVT_W-1:0] inc,
    input  logic             load_en,
    input  logic [ACC_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_q
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } acc_st_t;

    acc_st_t        st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + (ACC_W+1)'(inc);
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (load_en) begin
            st_d.acc = load_val;
        end else if (cnt_en) begin
            st_d.acc = sum[ACC_W-1:0];
            if (sum[ACC_W]) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q = st_q.acc;
    assign ovf_q = st_q.ovf;

    // R11
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (acc_q == $past(load_val)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !cnt_en) |=> $stable(acc_q));

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R12
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(cnt_en && !load_en));

endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
    import evt_thr_pkg::*;
#(
    parameter int EVT_W   = 8,
    parameter int ACC_W   = 64,
    parameter int THR_MAX = 255
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cnt_en,
    input  logic [EVT_W-1:0]       evt_count,
    input  logic                   cfg_wr,
    input  logic [THR_FIELD_W-1:0] cfg_thresh,
    input  logic [1:0]             cfg_cmp,
    input  logic                   cfg_unit,
    input  logic                   load_en,
    input  logic [ACC_W-1:0]       load_val,
    input  logic                   ovf_clr,
    output logic [ACC_W-1:0]       acc_out,
    output logic                   ovf_flag,
    output logic                   cfg_err,
    output logic [THR_FIELD_W-1:0] thresh_cap
);

    thr_cfg_t         wr_cfg;
    thr_cfg_t         cfg_q;
    logic [EVT_W-1:0] inc;

    always_comb begin
        wr_cfg.thresh = cfg_thresh;
        wr_cfg.cmp    = cmp_sel_e'(cfg_cmp);
        wr_cfg.unit   = cfg_unit;
    end

    evt_thr_cfg #(.THR_MAX(THR_MAX)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q),
        .err_q  (cfg_err),
        .cap    (thresh_cap)
    );

    evt_thr_qual #(.EVT_W(EVT_W)) qual_i (
        .evt (evt_count),
        .cfg (cfg_q),
        .inc (inc)
    );

    evt_thr_accum #(.ACC_W(ACC_W), .EVT_W(EVT_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .inc      (inc),
        .load_en  (load_en),
        .load_val (load_val),
        .ovf_clr  (ovf_clr),
        .acc_q    (acc_out),
        .ovf_q    (ovf_flag)
    );

    // R9
    no_cap_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (thresh_cap == '0) && (cfg_thresh != '0)) |=> cfg_err);

endmodule

// File: tb/evt_thresh_counter_tb_top.sv
module evt_thresh_counter_tb_top;

    localparam int EW = 8;
    localparam int AW = 16;
    localparam int TM = 255;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnt_en;
    logic [EW-1:0] evt_count;
    logic          cfg_wr;
    logic [11:0]   cfg_thresh;
    logic [1:0]    cfg_cmp;
    logic          cfg_unit;
    logic          load_en;
    logic [AW-1:0] load_val;
    logic          ovf_clr;
    logic [AW-1:0] acc_out;
    logic          ovf_flag;
    logic          cfg_err;
    logic [11:0]   thresh_cap;
    logic [AW-1:0] acc_z;
    logic          ovf_z;
    logic          err_z;
    logic [11:0]   cap_z;

    always #10 clk = ~clk;

    evt_thresh_counter #(.EVT_W(EW), .ACC_W(AW), .THR_MAX(TM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_count(evt_count),
        .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh), .cfg_cmp(cfg_cmp),
        .cfg_unit(cfg_unit), .load_en(load_en), .load_val(load_val),
        .ovf_clr(ovf_clr), .acc_out(acc_out), .ovf_flag(ovf_flag),
        .cfg_err(cfg_err), .thresh_cap(thresh_cap)
    );

    evt_thresh_counter #(.EVT_W(EW), .ACC_W(AW), .THR_MAX(0)) dut_nocap_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_count(evt_count),
        .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh), .cfg_cmp(cfg_cmp),
        .cfg_unit(cfg_unit), .load_en(load_en), .load_val(load_val),
        .ovf_clr(ovf_clr), .acc_out(acc_z), .ovf_flag(ovf_z),
        .cfg_err(err_z), .thresh_cap(cap_z)
    );

    typedef struct {
        logic [AW-1:0] acc;
        logic          ovf;
        logic          err;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // model state
    logic [11:0]   m_thr  = '0;
    logic [1:0]    m_cmp  = '0;
    logic          m_unit = 1'b0;
    logic [AW-1:0] m_acc  = '0;
    logic          m_ovf  = 1'b0;
    logic          m_err  = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit en, input int evt, input bit wr, input int thr,
                        input int cmp, input bit unit, input bit ld, input int ldv,
                        input bit clr, input string tag);
        logic [AW:0] sum;
        int          inc;
        bit          hit;
        exp_t        e;
        @(negedge clk);
        cnt_en = en; evt_count = EW'(evt); cfg_wr = wr; cfg_thresh = 12'(thr);
        cfg_cmp = 2'(cmp); cfg_unit = unit; load_en = ld; load_val = AW'(ldv);
        ovf_clr = clr;
        case (m_cmp)
            2'd0: hit = (evt != int'(m_thr));
            2'd1: hit = (evt == int'(m_thr));
            2'd2: hit = (evt >= int'(m_thr));
            default: hit = (evt < int'(m_thr));
        endcase
        if (m_thr == 0) inc = evt;
        else if (!hit) inc = 0;
        else if (m_unit) inc = 1;
        else inc = evt;
        if (clr) m_ovf = 1'b0;
        if (ld) m_acc = AW'(ldv);
        else if (en) begin
            sum = {1'b0, m_acc} + (AW+1)'(inc);
            m_acc = sum[AW-1:0];
            if (sum[AW]) m_ovf = 1'b1;
        end
        if (wr) begin
            m_err = (thr > TM);
            if (thr <= TM) begin
                m_thr = 12'(thr); m_cmp = 2'(cmp); m_unit = unit;
            end
        end
        e.acc = m_acc; e.ovf = m_ovf; e.err = m_err; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (acc_out !== e.acc || ovf_flag !== e.ovf || cfg_err !== e.err) begin
                    errors++;
                    $display("FAIL %s actual acc=%0h ovf=%b err=%b expected acc=%0h ovf=%b err=%b",
                             e.tag, acc_out, ovf_flag, cfg_err, e.acc, e.ovf, e.err);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt_en = 0; evt_count = '0; cfg_wr = 0; cfg_thresh = '0;
        cfg_cmp = '0; cfg_unit = 0; load_en = 0; load_val = '0; ovf_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(acc_out == '0, "R1 acc", acc_out, 0);
        check(ovf_flag == 0, "R1 ovf", ovf_flag, 0);
        check(cfg_err == 0, "R1 err", cfg_err, 0);
        // R6 capability
        check(thresh_cap == 12'd255, "R6 cap", thresh_cap, 255);
        check(cap_z == 12'd0, "R9 cap zero", cap_z, 0);

        // R1/R2: threshold zero counts raw, selector and unit ignored
        step(1, 5,   0, 0, 1, 1, 0, 0, 0, "R2 raw 5");
        step(1, 0,   0, 0, 3, 1, 0, 0, 0, "R2 raw 0");
        step(1, 200, 0, 0, 2, 1, 0, 0, 0, "R2 raw 200");
        // R7: write NE/4 while counting; old config governs this cycle
        step(1, 7,   1, 4, 0, 0, 0, 0, 0, "R7 write edge uses old cfg");
        @(posedge clk); #6;
        check(err_z == 1'b1, "R9 nonzero thr rejected with cap 0", err_z, 1);
        // R3/R4 not-equal
        step(1, 4,   0, 0, 0, 0, 0, 0, 0, "R3 NE equal evt adds 0");
        step(1, 9,   0, 0, 0, 0, 0, 0, 0, "R4 NE adds 9");
        // equal
        step(1, 3,   1, 4, 1, 0, 0, 0, 0, "R3 NE 3 adds 3");
        step(1, 4,   0, 0, 0, 0, 0, 0, 0, "R3 EQ 4 adds 4");
        step(1, 5,   0, 0, 0, 0, 0, 0, 0, "R3 EQ 5 adds 0");
        // greater-or-equal
        step(1, 3,   1, 4, 2, 0, 0, 0, 0, "R3 EQ 3 adds 0");
        step(1, 3,   0, 0, 0, 0, 0, 0, 0, "R3 GE 3 adds 0");
        step(1, 4,   0, 0, 0, 0, 0, 0, 0, "R3 GE 4 adds 4");
        step(1, 250, 0, 0, 0, 0, 0, 0, 0, "R4 GE 250 adds 250");
        // less-than
        step(1, 3,   1, 4, 3, 0, 0, 0, 0, "R3 GE 3 adds 0 at write");
        step(1, 3,   0, 0, 0, 0, 0, 0, 0, "R3 LT 3 adds 3");
        step(1, 4,   0, 0, 0, 0, 0, 0, 0, "R3 LT 4 adds 0");
        // R5 unit mode
        step(1, 2,   1, 4, 3, 1, 0, 0, 0, "R5 write unit");
        step(1, 2,   0, 0, 0, 0, 0, 0, 0, "R5 LT unit 2 adds 1");
        step(1, 0,   0, 0, 0, 0, 0, 0, 0, "R5 LT unit 0 adds 1");
        step(1, 9,   0, 0, 0, 0, 0, 0, 0, "R5 LT unit 9 adds 0");
        step(1, 200, 1, 4, 2, 1, 0, 0, 0, "R5 write GE unit");
        step(1, 200, 0, 0, 0, 0, 0, 0, 0, "R5 GE unit 200 adds 1");
        // R8 reject above capability
        step(1, 9,   1, 256, 1, 0, 0, 0, 0, "R8 reject 256");
        step(1, 9,   0, 0, 0, 0, 0, 0, 0, "R8 old cfg kept adds 1");
        // R7 accept at capability clears error
        step(1, 9,   1, 255, 2, 0, 0, 0, 0, "R7 accept 255");
        step(1, 255, 0, 0, 0, 0, 0, 0, 0, "R7 GE 255 adds 255");
        step(1, 254, 0, 0, 0, 0, 0, 0, 0, "R7 GE 254 adds 0");
        step(1, 255, 1, 4095, 0, 1, 0, 0, 0, "R8 reject 4095");
        step(1, 255, 0, 0, 0, 0, 0, 0, 0, "R8 cfg still GE 255");
        // R10 disabled
        step(0, 255, 0, 0, 0, 0, 0, 0, 0, "R10 hold");
        step(0, 10,  0, 0, 0, 0, 0, 0, 0, "R10 hold again");
        // R11 load priority, also switch to threshold zero
        step(1, 255, 1, 0, 0, 0, 1, 32'hFFF0, 0, "R11 load over count");
        // R12 wrap
        step(1, 32,  0, 0, 0, 0, 0, 0, 0, "R12 wrap sets ovf");
        step(1, 0,   0, 0, 0, 0, 0, 0, 0, "R12 ovf sticky");
        step(0, 0,   0, 0, 0, 0, 0, 0, 1, "R12 ovf cleared");
        step(0, 0,   0, 0, 0, 0, 1, 32'hFFFF, 0, "R11 load full scale");
        step(1, 1,   0, 0, 0, 0, 0, 0, 1, "R12 wrap beats clear");
        step(0, 0,   0, 0, 0, 0, 0, 0, 0, "R10 idle end");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule